// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers sixteen interrupt sources for a small 8-bit processor core. It decides at which instruction boundary the core should branch into a service routine, and to which vector. Every source has three bits: a pending flag, an individual enable and a priority bit that selects the low or the high level. One global enable sits above all of them. Pending flags are set by hardware event pulses whether or not the source is enabled. Software can also write them. A chosen subset of the flags clears itself when its vector is accepted. The other flags stay set until software clears them.

The core reports each completed instruction on `instr_done`. With the same strobe it states whether the instruction about to start is multi-cycle. The core pulses `ret_strb` when a return-from-interrupt completes. The controller offers a vector as a valid/ready stream of source index and branch address. Once `vec_valid` is raised, the index and address stay unchanged until the core takes them with `vec_ready`. The controller makes no new decision while an offer is outstanding. The core may hold `vec_ready` low for as many cycles as it needs. Nesting is tracked with one in-service bit per level. A register port gives software direct access to the pending, enable, priority and control words.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every pending, enable and priority bit and the global enable read 0, both in-service bits are clear, and `vec_valid` is 0.
- R2: A pulse on `src_evt[n]` sets pending bit n even while source n is disabled. Register address 0 holds the pending word, address 1 the enables, address 2 the priorities (1 = high level), and bit 0 of address 3 the global enable.
- R3: A vector is offered only for a source whose pending flag is set and whose enable is set, and only while the global enable is in effect. With the global enable at 0 no source is offered.
- R4: A decision is made only in a cycle where `instr_done` is 1. `vec_valid` rises in the following cycle with `vec_idx` = n and `vec_addr` = 0x0003 + 8*n.
- R5: Software writing a 1 into a pending bit through address 0 produces the same vector as a hardware event.
- R6: When a vector is accepted (`vec_valid` and `vec_ready` both 1), the pending flag of that source is cleared if its bit is set in the AUTOCLR parameter (default 0x000F, sources 0 to 3). All other flags stay set.
- R7: An `instr_done` in the same cycle as `ret_strb` makes no decision. A flag still pending and enabled is taken at the next boundary after the return.
- R8: Writing 0 to the global enable while it is 1 takes effect at once for reads. For the first boundary after that write, the controller still honours the old value if `next_multi` is 0, and does not honour it if `next_multi` is 1.
- R9: A high-level request may preempt a low-level routine. Nothing preempts a high-level routine, and a low-level request does not preempt a low-level routine.
- R10: Among eligible requests the high level wins. Within one level the lowest source index wins.
- R11: While `vec_valid` is 1 and `vec_ready` is 0, `vec_valid`, `vec_idx` and `vec_addr` hold their values.
- R12: `ret_strb` clears the high in-service bit if it is set, and the low one otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Per-source event pulses that set pending flags |
| instr_done | input | 1 | Instruction boundary strobe |
| next_multi | input | 1 | With instr_done: the next instruction is multi-cycle |
| ret_strb | input | 1 | Return-from-interrupt completed |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | Core accepts the offered vector |
| vec_idx | output | 4 | Source index of the offered vector |
| vec_addr | output | 16 | Branch address of the offered vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
Arbitration is exercised with a single enabled source, with two high-level sources pending together, and with a high-level and a low-level source pending together. These cases separate the within-level index order from the level order. Masking is tried three ways: a disabled but pending source, a global enable held at 0, and a global enable cleared just before a boundary with each value of `next_multi`. Together they show the grace window is exactly one boundary and is controlled by that pin. Nesting sequences drive boundaries during low and high routines, and a boundary that coincides with a return. A stalled `vec_ready` with a new lower-index request arriving shows that the offer stays frozen.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_EN   = 2'd1,
    RA_PRIO = 2'd2,
    RA_CTL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC = 16,
  parameter logic [NSRC-1:0] AUTOCLR = '0,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  input  logic             clr_fire,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             instr_done,
  input  logic             next_multi,
  output logic [NSRC-1:0]  pend_q,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  prio_q,
  output logic             ge_eff
);
  reg_addr_e ra;
  logic wr_pend, wr_en, wr_prio, wr_ctl;
  logic ge_q, grace_q;
  logic [NSRC-1:0] clr_mask, pend_d;

  assign ra      = reg_addr_e'(reg_addr);
  assign wr_pend = reg_wr && (ra == RA_PEND);
  assign wr_en   = reg_wr && (ra == RA_EN);
  assign wr_prio = reg_wr && (ra == RA_PRIO);
  assign wr_ctl  = reg_wr && (ra == RA_CTL);

  // Auto-clear on acceptance; a software write replaces the word; events always set.
  always_comb begin
    clr_mask = '0;
    if (clr_fire && AUTOCLR[clr_idx]) clr_mask[clr_idx] = 1'b1;
    pend_d = wr_pend ? reg_wdata : (pend_q & ~clr_mask);
    pend_d = pend_d | src_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_en)   en_q   <= reg_wdata;
      if (wr_prio) prio_q <= reg_wdata;
    end
  end

  // Global enable with a one-boundary grace window after a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge_q    <= 1'b0;
      grace_q <= 1'b0;
    end else if (wr_ctl) begin
      ge_q    <= reg_wdata[0];
      grace_q <= ge_q && !reg_wdata[0];
    end else if (instr_done) begin
      grace_q <= 1'b0;
    end
  end

  assign ge_eff = ge_q | (grace_q & ~next_multi);

  always_comb begin
    unique case (ra)
      RA_PEND: reg_rdata = pend_q;
      RA_EN:   reg_rdata = en_q;
      RA_PRIO: reg_rdata = prio_q;
      default: reg_rdata = {{(NSRC-1){1'b0}}, ge_q};
    endcase
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Lowest set index wins.
  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  lvl_e             take_lvl,
  input  logic             vec_ready,
  input  logic             ret_strb,
  output logic             vec_valid,
  output logic [IDX_W-1:0] vec_idx,
  output logic             acc_fire,
  output logic             isr_hi,
  output logic             isr_lo
);
  lvl_e vec_lvl;
  logic hi_d, lo_d;

  assign acc_fire = vec_valid & vec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      vec_lvl   <= LVL_LO;
    end else if (take) begin
      vec_valid <= 1'b1;
      vec_idx   <= take_idx;
      vec_lvl   <= take_lvl;
    end else if (acc_fire) begin
      vec_valid <= 1'b0;
    end
  end

  always_comb begin
    hi_d = isr_hi;
    lo_d = isr_lo;
    if (ret_strb) begin
      if (isr_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (acc_fire) begin
      if (vec_lvl == LVL_HI) hi_d = 1'b1;
      else                   lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else begin
      isr_hi <= hi_d;
      isr_lo <= lo_d;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NSRC-1:0] AUTOCLR = 16'h000F,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              instr_done,
  input  logic              next_multi,
  input  logic              ret_strb,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [IDX_W-1:0]  vec_idx,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata
);
  logic [NSRC-1:0] pend_q, en_q, prio_q, req;
  logic            ge_eff, acc_fire, isr_hi, isr_lo;
  logic [NSRC-1:0] cand  [2];
  logic            found [2];
  logic [IDX_W-1:0] pidx [2];
  logic            win_ok, take;
  logic [IDX_W-1:0] win_idx;
  lvl_e            win_lvl;

  irq_regs #(.NSRC(NSRC), .AUTOCLR(AUTOCLR)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_fire(acc_fire), .clr_idx(vec_idx),
    .instr_done(instr_done), .next_multi(next_multi),
    .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q), .ge_eff(ge_eff)
  );

  assign req     = pend_q & en_q;
  assign cand[0] = req & ~prio_q;
  assign cand[1] = req & prio_q;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_pick #(.N(NSRC)) u_pick (.cand(cand[g]), .found(found[g]), .idx(pidx[g]));
  end

  // Level gating: high may preempt low; nothing preempts high.
  always_comb begin
    win_ok  = 1'b0;
    win_idx = pidx[0];
    win_lvl = LVL_LO;
    if (found[1] && !isr_hi) begin
      win_ok  = 1'b1;
      win_idx = pidx[1];
      win_lvl = LVL_HI;
    end else if (found[0] && !isr_hi && !isr_lo) begin
      win_ok = 1'b1;
    end
  end

  assign take = instr_done & ~ret_strb & ~vec_valid & ge_eff & win_ok;

  irq_nest #(.IDX_W(IDX_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .take(take), .take_idx(win_idx), .take_lvl(win_lvl),
    .vec_ready(vec_ready), .ret_strb(ret_strb), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .acc_fire(acc_fire), .isr_hi(isr_hi), .isr_lo(isr_lo)
  );

  assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(vec_idx);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int IDX_W = 4,
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_done,
  input logic              ret_strb,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [IDX_W-1:0]  vec_idx,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              isr_hi,
  input logic              ge_eff
);
  assert_hold_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_idx) && $stable(vec_addr));

  assert_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(instr_done));

  assert_vec_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_addr == ADDR_W'(VEC_BASE + VEC_STRIDE * int'(vec_idx)));

  assert_not_at_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> !$past(ret_strb));

  assert_no_preempt_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> !$past(isr_hi));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(ge_eff));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ret_strb(ret_strb),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_idx(vec_idx), .vec_addr(vec_addr),
  .isr_hi(isr_hi), .ge_eff(ge_eff)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        instr_done = 1'b0, next_multi = 1'b0, ret_strb = 1'b0;
  logic        vec_valid, vec_ready = 1'b1;
  logic [3:0]  vec_idx;
  logic [15:0] vec_addr;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int total = 0, bad = 0;
  int exp_q[$];
  bit got_vec;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .instr_done(instr_done),
    .next_multi(next_multi), .ret_strb(ret_strb), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_idx(vec_idx), .vec_addr(vec_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic evt(input int n);
    src_evt[n] = 1'b1; tick(); src_evt = '0;
  endtask

  // Driver: expected vectors go to the scoreboard queue before the boundary.
  task automatic expect_vec(input int n);
    exp_q.push_back(n);
  endtask

  task automatic boundary(input bit multi);
    instr_done = 1'b1; next_multi = multi;
    tick();
    instr_done = 1'b0; next_multi = 1'b0;
    got_vec = vec_valid;
    tick();
  endtask

  task automatic ret();
    ret_strb = 1'b1; tick(); ret_strb = 1'b0;
  endtask

  // Monitor: values between edges are those seen at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected vector", vec_idx, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(vec_idx == e, "R4 R10 vector index", vec_idx, e);
        chk(vec_addr == 16'(3 + 8 * e), "R4 vector address", vec_addr, 3 + 8 * e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk(vec_valid == 1'b0, "R1 vec_valid after reset", vec_valid, 0);
    rd(2'd0, 16'h0000, "R1 pending after reset");
    rd(2'd1, 16'h0000, "R1 enable after reset");
    rd(2'd2, 16'h0000, "R1 priority after reset");
    rd(2'd3, 16'h0000, "R1 control after reset");
    rst_n = 1'b1;
    tick();

    // R2: disabled source latches its flag; R3: no vector while disabled
    wr(2'd3, 16'h0001);
    evt(5);
    rd(2'd0, 16'h0020, "R2 pending latched while disabled");
    boundary(1'b0);
    chk(!got_vec, "R3 disabled source offered", got_vec, 0);

    // R3: global enable 0 masks; grace consumed by a multi-cycle boundary first
    wr(2'd1, 16'h0020);
    wr(2'd3, 16'h0000);
    boundary(1'b1);
    chk(!got_vec, "R8 multi-cycle after clear took vector", got_vec, 0);
    boundary(1'b0);
    chk(!got_vec, "R3 global enable 0 took vector", got_vec, 0);

    // R4: simple low-level vector for source 5 (not auto-cleared, R6)
    wr(2'd3, 16'h0001);
    expect_vec(5);
    boundary(1'b0);
    chk(got_vec, "R4 vector after boundary", got_vec, 1);
    rd(2'd0, 16'h0020, "R6 non-autoclear flag kept");
    boundary(1'b0);
    chk(!got_vec, "R9 low preempted low", got_vec, 0);

    // R5 + R9: software-set high source 9 preempts low routine
    wr(2'd2, 16'h0204);
    wr(2'd1, 16'h0224);
    wr(2'd0, 16'h0220);
    expect_vec(9);
    boundary(1'b0);
    chk(got_vec, "R5 software flag vectored", got_vec, 1);
    // R9: high source 2 must not preempt high routine
    wr(2'd0, 16'h0224);
    boundary(1'b0);
    chk(!got_vec, "R9 high preempted high", got_vec, 0);

    // R7 + R12: boundary at return makes no decision; return pops high level
    ret_strb = 1'b1; instr_done = 1'b1;
    tick();
    ret_strb = 1'b0; instr_done = 1'b0;
    got_vec = vec_valid;
    tick();
    chk(!got_vec, "R7 decision at return", got_vec, 0);
    // R10: sources 2 and 9 both high, lowest index wins; R12 high popped, low still active
    expect_vec(2);
    boundary(1'b0);
    rd(2'd0, 16'h0220, "R6 auto-clear of source 2");
    ret();
    // R7: source 9 still pending re-fires at next boundary
    expect_vec(9);
    boundary(1'b0);
    chk(got_vec, "R7 re-fire after return", got_vec, 1);
    ret();
    wr(2'd0, 16'h0000);
    // R12: low routine still active, so low source 5 cannot enter until popped
    wr(2'd0, 16'h0020);
    boundary(1'b0);
    chk(!got_vec, "R12 low level popped too early", got_vec, 0);
    wr(2'd0, 16'h0000);
    ret();

    // R11: back-pressure holds the offer
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0082);
    wr(2'd0, 16'h0080);
    expect_vec(7);
    vec_ready = 1'b0;
    boundary(1'b0);
    wr(2'd0, 16'h0082);
    boundary(1'b0);
    for (int i = 0; i < 3; i++) begin
      chk(vec_valid == 1'b1, "R11 valid held", vec_valid, 1);
      chk(vec_idx == 4'd7, "R11 index held", vec_idx, 7);
      tick();
    end
    vec_ready = 1'b1;
    tick();
    chk(vec_valid == 1'b0, "R11 dropped after accept", vec_valid, 0);
    wr(2'd0, 16'h0000);
    ret();

    // R8: clear global enable, single-cycle next instruction still takes
    wr(2'd1, 16'h0010);
    wr(2'd3, 16'h0000);
    evt(4);
    rd(2'd3, 16'h0000, "R8 global enable reads 0");
    expect_vec(4);
    boundary(1'b0);
    chk(got_vec, "R8 grace window vector", got_vec, 1);
    wr(2'd0, 16'h0000);
    ret();
    // R8: multi-cycle next instruction blocks, and the window closes
    wr(2'd3, 16'h0001);
    wr(2'd3, 16'h0000);
    evt(4);
    boundary(1'b1);
    chk(!got_vec, "R8 multi-cycle next took vector", got_vec, 0);
    boundary(1'b0);
    chk(!got_vec, "R8 window persisted", got_vec, 0);
    wr(2'd0, 16'h0000);

    // R10: high source 12 beats low source 3 despite higher index
    wr(2'd1, 16'h1008);
    wr(2'd2, 16'h1000);
    wr(2'd0, 16'h1008);
    wr(2'd3, 16'h0001);
    expect_vec(12);
    boundary(1'b0);
    wr(2'd0, 16'h0008);
    ret();
    expect_vec(3);
    boundary(1'b0);
    rd(2'd0, 16'h0000, "R6 auto-clear of source 3");
    ret();

    chk(exp_q.size() == 0, "R4 missing expected vectors", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule